// File: doc/BRIEF.md
# Two-Slice Cascaded Priority Encoder (Active-Low)

This block turns sixteen active-low request lines into a four-bit active-low code naming the highest-numbered request that is asserted. It is built from two identical eight-input priority slices. The upper slice covers requests 8 to 15 and is enabled straight from the block's own enable input. Its enable-out drives the enable-in of the lower slice, which covers requests 0 to 7. The lower slice therefore takes part only when no upper request is asserted.

The code's top bit is the upper slice's group-select, which goes low whenever one of requests 8 to 15 is asserted. The three lower bits are the bitwise AND of the two slices' active-low codes. A slice that is idle or disabled drives all ones, so the AND passes through the code of the slice that is working. The block is purely combinational. It brings out an overall enable-in, enable-out and group-select, so that a wider encoder can be chained from several copies.

Top module: `prio_enc16_n`

## Requirements
- R1: With enInN high, the block is disabled whatever the requests: codeN is 4'b1111, grpSelN is 1 and enOutN is 1.
- R2: With enInN low and all sixteen reqN bits high, codeN is 4'b1111, grpSelN is 1 and enOutN is 0.
- R3: With enInN low and at least one reqN bit low, grpSelN is 0 and enOutN is 1.
- R4: With enInN low, codeN is the bitwise inverse of the index of the highest-numbered low bit of reqN. Bit 3 of codeN is the most significant bit of the index.
- R5: When any of reqN[15:8] is low, codeN[3] is 0 and codeN does not change with the value of reqN[7:0].
- R6: When reqN[15:8] are all high and some bit of reqN[7:0] is low, codeN[3] is 1 and codeN[2:0] is the inverse of that lower index.
- R7: A lone request on line 12 gives codeN 4'b0011, which is binary 12 inverted. Adding any lower requests gives the same code.
- R8: A lone request on line 6 gives codeN 4'b1001.
- R9: With all sixteen requests low, codeN is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| reqN | input | 16 | Request lines, active low; bit 15 has the highest priority |
| enInN | input | 1 | Cascade enable in, active low |
| codeN | output | 4 | Index of the highest active request, active low |
| grpSelN | output | 1 | Low when enabled and any request is active |
| enOutN | output | 1 | Low when enabled and no request is active; feeds the next lower stage |

## Verification
The bench works on the boundary between the slices. It drives patterns where an upper request sits over a dense set of lower requests. A broken enable chain would then let the lower slice's code bits leak into the AND and corrupt codeN[2:0]. It drives the idle and disabled cases and tells them apart only through enOutN, because a design that mixed up the two would pass on codeN alone. Lone requests on lines 0, 7, 8 and 15 check the bit order of the index and whether the top bit comes from group-select. Sparse and dense random patterns are compared against a reference scan done in the bench.

// File: rtl/prio_enc_pkg.sv
package prio_enc_pkg;
  // strobes from control into the datapath
  typedef struct packed {
    logic loEnN;   // enable for the lower slice, active low
  } encStrobes_t;

  // status returned by one slice
  typedef struct packed {
    logic gsN;     // group select, active low
    logic eoN;     // enable out, active low
  } sliceStat_t;
endpackage

// File: rtl/prio_slice.sv
module prio_slice #(
  parameter int W  = 8,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  reqN,
  input  logic          enInN,
  output logic [CW-1:0] codeN,
  output logic          gsN,
  output logic          eoN
);
  logic [CW-1:0] topIdx;
  logic          anyReq;

  // scan upward so the highest active line wins
  always_comb begin
    topIdx = '0;
    anyReq = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (!reqN[i]) begin
        topIdx = CW'(i);
        anyReq = 1'b1;
      end
    end
  end

  always_comb begin
    if (enInN) begin
      codeN = '1;
      gsN   = 1'b1;
      eoN   = 1'b1;
    end else if (anyReq) begin
      codeN = ~topIdx;
      gsN   = 1'b0;
      eoN   = 1'b1;
    end else begin
      codeN = '1;
      gsN   = 1'b1;
      eoN   = 1'b0;
    end
  end
endmodule

// File: rtl/prio_enc_ctrl.sv
module prio_enc_ctrl
  import prio_enc_pkg::*;
(
  input  sliceStat_t  hiStat,
  input  sliceStat_t  loStat,
  output encStrobes_t strobes,
  output logic        grpSelN,
  output logic        enOutN
);
  // upper slice hands enable down only when it is idle
  always_comb begin
    strobes.loEnN = hiStat.eoN;
    grpSelN       = hiStat.gsN & loStat.gsN;
    enOutN        = loStat.eoN;
  end
endmodule

// File: rtl/prio_enc_dp.sv
module prio_enc_dp
  import prio_enc_pkg::*;
#(
  parameter int SLICE_W = 8,
  parameter int SEL_W   = $clog2(SLICE_W)
) (
  input  logic [2*SLICE_W-1:0] reqN,
  input  logic                 enInN,
  input  encStrobes_t          strobes,
  output sliceStat_t           hiStat,
  output sliceStat_t           loStat,
  output logic [SEL_W:0]       codeN
);
  logic [SEL_W-1:0] hiCodeN;
  logic [SEL_W-1:0] loCodeN;
  logic             hiGs, hiEo, loGs, loEo;

  prio_slice #(.W(SLICE_W), .CW(SEL_W)) u_hiSlice (
    .reqN  (reqN[2*SLICE_W-1:SLICE_W]),
    .enInN (enInN),
    .codeN (hiCodeN),
    .gsN   (hiGs),
    .eoN   (hiEo)
  );

  prio_slice #(.W(SLICE_W), .CW(SEL_W)) u_loSlice (
    .reqN  (reqN[SLICE_W-1:0]),
    .enInN (strobes.loEnN),
    .codeN (loCodeN),
    .gsN   (loGs),
    .eoN   (loEo)
  );

  assign hiStat = '{gsN: hiGs, eoN: hiEo};
  assign loStat = '{gsN: loGs, eoN: loEo};

  // idle slice drives ones, so AND merges the two codes
  for (genvar b = 0; b < SEL_W; b++) begin : g_merge
    assign codeN[b] = hiCodeN[b] & loCodeN[b];
  end
  assign codeN[SEL_W] = hiGs;
endmodule

// File: rtl/prio_enc16_n.sv
module prio_enc16_n
  import prio_enc_pkg::*;
#(
  parameter int SLICE_W = 8,
  localparam int SEL_W  = $clog2(SLICE_W),
  localparam int IN_W   = 2 * SLICE_W,
  localparam int CODE_W = SEL_W + 1
) (
  input  logic [IN_W-1:0]   reqN,
  input  logic              enInN,
  output logic [CODE_W-1:0] codeN,
  output logic              grpSelN,
  output logic              enOutN
);
  encStrobes_t strobes;
  sliceStat_t  hiStat;
  sliceStat_t  loStat;

  prio_enc_ctrl u_ctrl (
    .hiStat  (hiStat),
    .loStat  (loStat),
    .strobes (strobes),
    .grpSelN (grpSelN),
    .enOutN  (enOutN)
  );

  prio_enc_dp #(.SLICE_W(SLICE_W), .SEL_W(SEL_W)) u_dp (
    .reqN    (reqN),
    .enInN   (enInN),
    .strobes (strobes),
    .hiStat  (hiStat),
    .loStat  (loStat),
    .codeN   (codeN)
  );
endmodule

// File: rtl/prio_enc16_n_chk.sv
module prio_enc16_n_chk #(
  parameter int IN_W   = 16,
  parameter int CODE_W = 4
) (
  input logic [IN_W-1:0]   reqN,
  input logic              enInN,
  input logic [CODE_W-1:0] codeN,
  input logic              grpSelN,
  input logic              enOutN
);
  localparam int HALF = IN_W / 2;

  always_comb begin
    if (!$isunknown({reqN, enInN})) begin
      if (enInN) begin
        p_disabled_idle_r1: assert (codeN == '1 && grpSelN && enOutN)
          else $error("R1 disabled outputs wrong");
      end
      if (!enInN && reqN == '1) begin
        p_no_request_r2: assert (codeN == '1 && grpSelN && !enOutN)
          else $error("R2 idle outputs wrong");
      end
      if (!enInN && reqN != '1) begin
        p_request_flags_r3: assert (!grpSelN && enOutN)
          else $error("R3 flags wrong");
      end
      if (!enInN && reqN[IN_W-1:HALF] != '1) begin
        p_upper_msb_r5: assert (!codeN[CODE_W-1])
          else $error("R5 top bit wrong");
      end
      if (!enInN && reqN[IN_W-1:HALF] == '1 && reqN[HALF-1:0] != '1) begin
        p_lower_msb_r6: assert (codeN[CODE_W-1])
          else $error("R6 top bit wrong");
      end
      if (!enInN && reqN == '0) begin
        p_all_active_r9: assert (codeN == '0)
          else $error("R9 all-active code wrong");
      end
    end
  end
endmodule

bind prio_enc16_n prio_enc16_n_chk #(.IN_W(IN_W), .CODE_W(CODE_W)) u_chk (
  .reqN    (reqN),
  .enInN   (enInN),
  .codeN   (codeN),
  .grpSelN (grpSelN),
  .enOutN  (enOutN)
);

// File: tb/prio_enc16_n_tb.sv
module prio_enc16_n_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] reqN = '1;
  logic        enInN = 1'b1;
  logic [3:0]  codeN;
  logic        grpSelN;
  logic        enOutN;
  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  prio_enc16_n u_dut (
    .reqN    (reqN),
    .enInN   (enInN),
    .codeN   (codeN),
    .grpSelN (grpSelN),
    .enOutN  (enOutN)
  );

  // reference model: {code, gs, eo}
  function automatic logic [5:0] refModel(input logic [15:0] r, input logic en);
    logic [3:0] idx;
    logic       hit;
    idx = '0;
    hit = 1'b0;
    if (en) return 6'b111111;
    for (int i = 0; i < 16; i++) begin
      if (!r[i]) begin
        idx = 4'(i);
        hit = 1'b1;
      end
    end
    if (hit) return {~idx, 1'b0, 1'b1};
    return 6'b111110;
  endfunction

  task automatic applyCheck(input logic [15:0] r, input logic en, input string tag);
    logic [5:0] exp;
    @(posedge clk);
    reqN  = r;
    enInN = en;
    @(negedge clk);
    exp = refModel(r, en);
    nChecks++;
    if ({codeN, grpSelN, enOutN} !== exp) begin
      nFails++;
      $display("FAIL %s req=%h en=%b got code=%b gs=%b eo=%b exp code=%b gs=%b eo=%b",
               tag, r, en, codeN, grpSelN, enOutN, exp[5:2], exp[1], exp[0]);
    end
  endtask

  task automatic checkCode(input logic [15:0] r, input logic [3:0] expCode, input string tag);
    @(posedge clk);
    reqN  = r;
    enInN = 1'b0;
    @(negedge clk);
    nChecks++;
    if (codeN !== expCode) begin
      nFails++;
      $display("FAIL %s req=%h got code=%b exp code=%b", tag, r, codeN, expCode);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        nChecks++;
        nFails++;
        $display("FAIL watchdog expired got cycles=%0d exp below 50000", cyc);
        finishRun();
      end
    end
  end

  initial begin
    logic [15:0] base;
    int unsigned seedVal;
    seedVal = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // R1 disabled/reset state
    @(negedge clk);
    nChecks++;
    if ({codeN, grpSelN, enOutN} !== 6'b111111) begin
      nFails++;
      $display("FAIL R1 reset state got %b exp 111111", {codeN, grpSelN, enOutN});
    end
    applyCheck(16'h0000, 1'b1, "R1 disabled with all requests");
    applyCheck(16'h7ffe, 1'b1, "R1 disabled with mixed requests");

    // R2 idle
    applyCheck(16'hffff, 1'b0, "R2 idle");

    // R7 / R8 examples from the requirements
    checkCode(16'hefff, 4'b0011, "R7 lone line 12");
    checkCode(16'hef00, 4'b0011, "R7 line 12 with lower requests");
    checkCode(16'hffbf, 4'b1001, "R8 lone line 6");

    // R9 all active
    checkCode(16'h0000, 4'b0000, "R9 all active");

    // R4 index bit order at slice edges
    checkCode(16'hfffe, 4'b1111, "R4 lone line 0");
    checkCode(16'hff7f, 4'b1000, "R4 lone line 7");
    checkCode(16'hfeff, 4'b0111, "R4 lone line 8");
    checkCode(16'h7fff, 4'b0000, "R4 lone line 15");

    // R5 upper request over dense lower patterns: code must not move
    for (int k = 0; k < 8; k++) begin
      logic [15:0] hiPat;
      hiPat = ~(16'h0100 << k);
      checkCode({hiPat[15:8], 8'h00}, ~4'(8 + k), "R5 upper over all lower");
      checkCode({hiPat[15:8], 8'h5a}, ~4'(8 + k), "R5 upper over mixed lower");
    end

    // R6 lower only
    for (int k = 0; k < 8; k++) begin
      checkCode({8'hff, ~(8'h01 << k)}, {1'b1, ~3'(k)}, "R6 lower only");
    end

    // R3/R4 random, sparse and dense
    for (int n = 0; n < 400; n++) begin
      case (n % 4)
        0: base = 16'($urandom());
        1: base = 16'($urandom() | $urandom() | $urandom());
        2: base = 16'($urandom() & $urandom());
        default: base = {8'hff, 8'($urandom() | $urandom())};
      endcase
      applyCheck(base, 1'b0, "R3 R4 random");
    end
    for (int n = 0; n < 40; n++) begin
      applyCheck(16'($urandom()), 1'b1, "R1 random disabled");
    end

    finishRun();
  end
endmodule